// File: doc/BRIEF.md
# Sealed Domain Call/Return Sequencer

This block carries out the state swap of a protected cross-domain call, and of the return that matches it. The operand is a sealed capability. Its base address selects a memory region split into slots of one capability word each, where slot i starts at base + i*(WORD_W/8). A call loads a new pc and argument registers out of that region. It then parks the caller's pc and stack pointer in the region and hands the caller a sealed-return capability in the return-address register. A return reloads the pc, plus either the whole register file or only the stack pointer. It then saves a resume pc and the callee's live registers into the region. Finally it re-seals the capability into the exception-handler register or into a register chosen by the capability.

The sequencer talks to a register file with one combinational read port and one write port, and to a word-wide memory port. That port carries one outstanding access at a time, under a valid/ready request handshake and a response strobe. Before the first load, every value that a later store needs (old pc, old sp, old argument registers) is copied into a private snapshot buffer. A load can therefore never corrupt a store.

States: IDLE (waits for start), FAULT (one cycle, raises the exception), SNAP (copies registers into the snapshot), LD_REQ/LD_RSP (issue a load, then wait for its data), ST_REQ (issue a store), WB (writes the re-sealed capability), FIN (pulses done). Transitions: IDLE→FAULT when a check fails, otherwise IDLE→SNAP. SNAP→LD_REQ once the last register is copied. LD_REQ→LD_RSP on ready. LD_RSP→LD_REQ while loads remain, and LD_RSP→ST_REQ after the last one. ST_REQ→WB after the last store. WB→FIN. FIN→IDLE and FAULT→IDLE.

Top module: `seal_xfer_seq`

## Requirements
- R1: While reset is held and right after it, busy, done, exc, mem_req_valid, rf_we, pc_we and ehr_we are all 0.
- R2: The block raises exc for exactly one cycle, the cycle after start, and makes no memory request and no register, pc or exception-handler write, in these cases: world_secure is 0, opnd_is_cap is 0, opnd_valid is 0, or the type is not 4 for a call (op_ret=0) or not 5 for a return (op_ret=1). done stays 0.
- R3: Slot i sits at opnd_base + i*(WORD_W/8). A capability word holds base in bits [A-1:0], reg in [A+4:A], count in [A+9:A+5], type in [A+12:A+10] and valid in bit A+13, with A=ADDR_W and every other bit 0. A pc word keeps its cursor in bits [A-1:0].
- R4: A call loads slot 0 into pc, then loads slots 1..count into x1..x[count] in ascending order.
- R5: After all of its loads, a call stores the pc value held at start into slot 0, then stores the value x2 held at start into slot 1.
- R6: A call ends by writing x1 with the operand re-encoded as valid with type 5, keeping base, count and reg.
- R7: A return whose reg field is 0 loads slot 0 into pc and slots 1..31 into x1..x31. It ends by writing the operand, re-encoded with type 4, to the exception-handler port.
- R8: A return whose reg field is nonzero loads slot 0 into pc and slot 1 into x2 only. It ends by writing the operand, re-encoded with type 4, into x[reg].
- R9: After its loads, a return stores into slot 0 the pc held at start, with bits [A-1:0] replaced by int_opnd. It then stores the values x1..x[count] held at start into slots 1..count.
- R10: Only one memory access is in flight at a time. A request holds its address, data and direction steady until ready. All loads are issued before any store.
- R11: done pulses for one cycle after the final register write. busy is high from the cycle after start until done or exc. A start pulse while busy is ignored.
- R12: Register x0 is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken in IDLE only) |
| op_ret | input | 1 | 0 = call, 1 = return |
| world_secure | input | 1 | Current world bit, 1 = secure |
| opnd_is_cap | input | 1 | Operand register holds a capability |
| opnd_valid | input | 1 | Operand valid bit |
| opnd_type | input | 3 | Operand type code |
| opnd_base | input | ADDR_W | Operand base address |
| opnd_count | input | $clog2(NREG) | Operand register count field |
| opnd_reg | input | $clog2(NREG) | Operand target register field |
| int_opnd | input | ADDR_W | Integer operand (resume cursor for a return) |
| cur_pc | input | WORD_W | Current pc word |
| rf_raddr | output | $clog2(NREG) | Register file read index |
| rf_rdata | input | WORD_W | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | $clog2(NREG) | Register file write index |
| rf_wdata | output | WORD_W | Register file write data |
| pc_we | output | 1 | pc write enable |
| pc_wdata | output | WORD_W | New pc word |
| ehr_we | output | 1 | Exception-handler register write enable |
| ehr_wdata | output | WORD_W | Exception-handler register data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | ADDR_W | Slot byte address |
| mem_req_wdata | output | WORD_W | Store data |
| mem_rsp_valid | input | 1 | Load data strobe |
| mem_rsp_rdata | input | WORD_W | Load data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | One-cycle exception pulse |

## Verification
The bench builds the block with ADDR_W=32, WORD_W=128 and NREG=32. The narrow address leaves a 128-bit capability word plenty of spare bits and keeps every test region small. It also keeps the full 5-bit count and reg fields, so counts of 0 and 31 and a full reload of the register file can be reached. A return that targets x2, which is also the register reloaded as sp, tests the write order. Runs with a stalling ready signal and a start pulse issued in mid-operation test the handshake hold and the rule that start is ignored while busy.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FAULT,
        ST_SNAP,
        ST_LD_REQ,
        ST_LD_RSP,
        ST_ST_REQ,
        ST_WB,
        ST_FIN
    } sxs_state_e;

    localparam int          TY_W       = 3;
    localparam logic [2:0]  TY_SEALED  = 3'd4;
    localparam logic [2:0]  TY_SEALRET = 3'd5;
    localparam int          RA_INDEX   = 1;
    localparam int          SP_INDEX   = 2;

endpackage

// File: rtl/sxs_guard.sv
module sxs_guard
    import sxs_pkg::*;
(
    input  logic            op_ret,
    input  logic            world_secure,
    input  logic            is_cap,
    input  logic            valid,
    input  logic [TY_W-1:0] ty,
    output logic            fault
);
    logic [TY_W-1:0] want_ty;

    always_comb begin
        want_ty = op_ret ? TY_SEALRET : TY_SEALED;
        fault   = !world_secure || !is_cap || !valid || (ty != want_ty);
    end
endmodule

// File: rtl/sxs_slot_addr.sv
module sxs_slot_addr #(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int SLOT_SH = $clog2(WORD_W / 8);

    always_comb begin
        addr = base + (ADDR_W'(idx) << SLOT_SH);
    end
endmodule

// File: rtl/sxs_shadow.sv
module sxs_shadow #(
    parameter int WORD_W = 128,
    parameter int NREG   = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] snap_q [NREG];

    always_ff @(posedge clk) begin
        if (we) begin
            snap_q[widx] <= wdata;
        end
    end

    always_comb begin
        rdata = snap_q[ridx];
    end
endmodule

// File: rtl/sxs_cap_pack.sv
module sxs_cap_pack
    import sxs_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic [TY_W-1:0]   ty,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  cnt,
    input  logic [IDX_W-1:0]  rg,
    output logic [WORD_W-1:0] word
);
    localparam int RG_LSB  = ADDR_W;
    localparam int CNT_LSB = ADDR_W + IDX_W;
    localparam int TY_LSB  = ADDR_W + 2 * IDX_W;
    localparam int VB_POS  = TY_LSB + TY_W;

    always_comb begin
        word                      = '0;
        word[ADDR_W-1:0]          = base;
        word[RG_LSB +: IDX_W]     = rg;
        word[CNT_LSB +: IDX_W]    = cnt;
        word[TY_LSB +: TY_W]      = ty;
        word[VB_POS]              = 1'b1;
    end
endmodule

// File: rtl/seal_xfer_seq.sv
module seal_xfer_seq
    import sxs_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 128,
    parameter int NREG   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    op_ret,
    input  logic                    world_secure,
    input  logic                    opnd_is_cap,
    input  logic                    opnd_valid,
    input  logic [2:0]              opnd_type,
    input  logic [ADDR_W-1:0]       opnd_base,
    input  logic [$clog2(NREG)-1:0] opnd_count,
    input  logic [$clog2(NREG)-1:0] opnd_reg,
    input  logic [ADDR_W-1:0]       int_opnd,
    input  logic [WORD_W-1:0]       cur_pc,
    output logic [$clog2(NREG)-1:0] rf_raddr,
    input  logic [WORD_W-1:0]       rf_rdata,
    output logic                    rf_we,
    output logic [$clog2(NREG)-1:0] rf_waddr,
    output logic [WORD_W-1:0]       rf_wdata,
    output logic                    pc_we,
    output logic [WORD_W-1:0]       pc_wdata,
    output logic                    ehr_we,
    output logic [WORD_W-1:0]       ehr_wdata,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [WORD_W-1:0]       mem_req_wdata,
    input  logic                    mem_rsp_valid,
    input  logic [WORD_W-1:0]       mem_rsp_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    exc
);
    localparam int IDX_W = $clog2(NREG);
    localparam logic [IDX_W-1:0] LAST_REG = IDX_W'(NREG - 1);
    localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);
    localparam logic [IDX_W-1:0] RA_IDX   = IDX_W'(RA_INDEX);
    localparam logic [IDX_W-1:0] SP_IDX   = IDX_W'(SP_INDEX);

    sxs_state_e state_q, state_d;

    // Operation context captured when start is taken
    logic              ret_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  rg_q;
    logic [ADDR_W-1:0] int_q;
    logic [WORD_W-1:0] oldpc_q;
    logic [IDX_W-1:0]  idx_q;

    // Derived sequencing limits
    logic              mode_nz;
    logic [IDX_W-1:0]  snap_last;
    logic [IDX_W-1:0]  ld_last;
    logic [IDX_W-1:0]  st_last;
    logic              snap_none;

    logic              fault;
    logic              snap_we;
    logic [WORD_W-1:0] snap_rdata;
    logic [WORD_W-1:0] sealed_word;
    logic [TY_W-1:0]   new_ty;
    logic [WORD_W-1:0] resume_pc;

    sxs_guard u_guard (
        .op_ret       (op_ret),
        .world_secure (world_secure),
        .is_cap       (opnd_is_cap),
        .valid        (opnd_valid),
        .ty           (opnd_type),
        .fault        (fault)
    );

    sxs_slot_addr #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .base (base_q),
        .idx  (idx_q),
        .addr (mem_req_addr)
    );

    sxs_shadow #(
        .WORD_W (WORD_W),
        .NREG   (NREG),
        .IDX_W  (IDX_W)
    ) u_shadow (
        .clk   (clk),
        .we    (snap_we),
        .widx  (idx_q),
        .wdata (rf_rdata),
        .ridx  (idx_q),
        .rdata (snap_rdata)
    );

    sxs_cap_pack #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_pack (
        .ty   (new_ty),
        .base (base_q),
        .cnt  (cnt_q),
        .rg   (rg_q),
        .word (sealed_word)
    );

    always_comb begin
        mode_nz   = (rg_q != '0);
        snap_last = ret_q ? cnt_q : ONE_IDX;
        snap_none = (snap_last == '0);
        ld_last   = !ret_q ? cnt_q : (mode_nz ? ONE_IDX : LAST_REG);
        st_last   = ret_q ? cnt_q : ONE_IDX;
        new_ty    = ret_q ? TY_SEALED : TY_SEALRET;
        resume_pc = {oldpc_q[WORD_W-1:ADDR_W], int_q};
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = fault ? ST_FAULT : ST_SNAP;
            ST_FAULT:  state_d = ST_IDLE;
            ST_SNAP:   if (snap_none || idx_q == snap_last) state_d = ST_LD_REQ;
            ST_LD_REQ: if (mem_req_ready) state_d = ST_LD_RSP;
            ST_LD_RSP: if (mem_rsp_valid) state_d = (idx_q == ld_last) ? ST_ST_REQ : ST_LD_REQ;
            ST_ST_REQ: if (mem_req_ready && idx_q == st_last) state_d = ST_WB;
            ST_WB:     state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Context and slot index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q   <= 1'b0;
            base_q  <= '0;
            cnt_q   <= '0;
            rg_q    <= '0;
            int_q   <= '0;
            oldpc_q <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ret_q   <= op_ret;
                        base_q  <= opnd_base;
                        cnt_q   <= opnd_count;
                        rg_q    <= opnd_reg;
                        int_q   <= int_opnd;
                        oldpc_q <= cur_pc;
                        idx_q   <= ONE_IDX;
                    end
                end
                ST_SNAP: begin
                    if (snap_none || idx_q == snap_last) idx_q <= '0;
                    else                                 idx_q <= idx_q + ONE_IDX;
                end
                ST_LD_RSP: begin
                    if (mem_rsp_valid) begin
                        if (idx_q == ld_last) idx_q <= '0;
                        else                  idx_q <= idx_q + ONE_IDX;
                    end
                end
                ST_ST_REQ: begin
                    if (mem_req_ready) idx_q <= idx_q + ONE_IDX;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = 1'b0;
        exc           = 1'b0;
        snap_we       = 1'b0;
        rf_raddr      = ret_q ? idx_q : SP_IDX;
        rf_we         = 1'b0;
        rf_waddr      = idx_q;
        rf_wdata      = mem_rsp_rdata;
        pc_we         = 1'b0;
        pc_wdata      = mem_rsp_rdata;
        ehr_we        = 1'b0;
        ehr_wdata     = sealed_word;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_wdata = (idx_q == '0) ? (ret_q ? resume_pc : oldpc_q) : snap_rdata;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FAULT: exc = 1'b1;
            ST_SNAP:  snap_we = !snap_none;
            ST_LD_REQ: mem_req_valid = 1'b1;
            ST_LD_RSP: begin
                if (mem_rsp_valid) begin
                    if (idx_q == '0) begin
                        pc_we = 1'b1;
                    end else begin
                        rf_we    = 1'b1;
                        rf_waddr = (ret_q && mode_nz) ? SP_IDX : idx_q;
                    end
                end
            end
            ST_ST_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
            end
            ST_WB: begin
                if (ret_q && !mode_nz) begin
                    ehr_we = 1'b1;
                end else begin
                    rf_we    = 1'b1;
                    rf_waddr = ret_q ? rg_q : RA_IDX;
                    rf_wdata = sealed_word;
                end
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/seal_xfer_seq_chk.sv
module seal_xfer_seq_chk #(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 128,
    parameter int NREG   = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    done,
    input logic                    exc,
    input logic                    mem_req_valid,
    input logic                    mem_req_ready,
    input logic                    mem_req_write,
    input logic [ADDR_W-1:0]       mem_req_addr,
    input logic [WORD_W-1:0]       mem_req_wdata,
    input logic                    rf_we,
    input logic [$clog2(NREG)-1:0] rf_waddr,
    input logic                    pc_we,
    input logic                    ehr_we,
    input logic [2:0]              ehr_type,
    input logic                    ehr_valid
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rf_we || ehr_we)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !rf_we && !pc_we && !ehr_we && !done); // R11

    AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> !mem_req_valid && !rf_we && !pc_we && !ehr_we && !done); // R2

    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |=> !exc && !busy); // R2

    AST_X0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_waddr != '0); // R12

    AST_EHR_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
        ehr_we |-> ehr_type == 3'd4 && ehr_valid); // R7
endmodule

bind seal_xfer_seq seal_xfer_seq_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .NREG   (NREG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .exc           (exc),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .pc_we         (pc_we),
    .ehr_we        (ehr_we),
    .ehr_type      (ehr_wdata[ADDR_W + 2*$clog2(NREG) +: 3]),
    .ehr_valid     (ehr_wdata[ADDR_W + 2*$clog2(NREG) + 3])
);

// File: tb/sim_seal_xfer_seq.sv
module sim_seal_xfer_seq;
    localparam int AW = 32;
    localparam int WW = 128;
    localparam int NR = 32;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          start = 0, op_ret = 0, world_secure = 0, opnd_is_cap = 0, opnd_valid = 0;
    logic [2:0]    opnd_type = 0;
    logic [AW-1:0] opnd_base = 0, int_opnd = 0;
    logic [IW-1:0] opnd_count = 0, opnd_reg = 0;
    logic [IW-1:0] rf_raddr, rf_waddr;
    logic [WW-1:0] rf_rdata, rf_wdata, pc_wdata, ehr_wdata, mem_req_wdata, mem_rsp_rdata;
    logic          rf_we, pc_we, ehr_we, mem_req_valid, mem_req_write, busy, done, exc;
    logic          mem_req_ready = 1'b1, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;

    // Bench models
    logic [WW-1:0] mem [NR];
    logic [WW-1:0] rf [NR];
    logic [WW-1:0] pc_q, ehr_q;
    logic [WW-1:0] mem_seed [NR];
    logic [WW-1:0] rf_seed [NR];
    logic [WW-1:0] pc_seed;
    logic          init_go = 0, log_clr = 0, stall_en = 0;
    logic [AW-1:0] cur_base = 0;
    logic [7:0]    stall_ctr = 0;
    logic          log_w [128];
    logic [IW-1:0] log_s [128];
    int            n_ops, traffic;
    logic          addr_bad;
    logic [AW-1:0] off;
    logic [IW-1:0] slot;
    logic          slot_bad;
    logic [WW-1:0] rsp_q;
    logic          rsp_v;

    assign off      = mem_req_addr - cur_base;
    assign slot     = off[IW+3:4];
    assign slot_bad = (off[3:0] != 0) || (off >= AW'(NR * 16));
    assign rf_rdata = rf[rf_raddr];
    assign mem_rsp_valid = rsp_v;
    assign mem_rsp_rdata = rsp_q;

    seal_xfer_seq #(.ADDR_W(AW), .WORD_W(WW), .NREG(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_ret(op_ret), .world_secure(world_secure),
        .opnd_is_cap(opnd_is_cap), .opnd_valid(opnd_valid), .opnd_type(opnd_type),
        .opnd_base(opnd_base), .opnd_count(opnd_count), .opnd_reg(opnd_reg),
        .int_opnd(int_opnd), .cur_pc(pc_q), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .ehr_we(ehr_we), .ehr_wdata(ehr_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .busy(busy), .done(done), .exc(exc));

    always @(negedge clk) begin
        stall_ctr     <= stall_ctr + 8'd1;
        mem_req_ready <= !stall_en || (stall_ctr % 3 == 2);
    end

    always @(posedge clk) begin
        rsp_v <= 1'b0;
        if (init_go) begin
            for (int i = 0; i < NR; i++) begin
                mem[i] <= mem_seed[i];
                rf[i]  <= rf_seed[i];
            end
            pc_q  <= pc_seed;
            ehr_q <= '0;
        end else begin
            if (rf_we)  rf[rf_waddr] <= rf_wdata;
            if (pc_we)  pc_q <= pc_wdata;
            if (ehr_we) ehr_q <= ehr_wdata;
            if (mem_req_valid && mem_req_ready && !slot_bad) begin
                if (mem_req_write) mem[slot] <= mem_req_wdata;
                else begin
                    rsp_v <= 1'b1;
                    rsp_q <= mem[slot];
                end
            end
        end
        if (log_clr) begin
            n_ops    <= 0;
            traffic  <= 0;
            addr_bad <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                if (n_ops < 128) begin
                    log_w[n_ops] <= mem_req_write;
                    log_s[n_ops] <= slot;
                end
                n_ops <= n_ops + 1;
                if (slot_bad) addr_bad <= 1'b1;
            end
            if (mem_req_valid || rf_we || pc_we || ehr_we) traffic <= traffic + 1;
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] mk(input int kind, input int cs, input int i);
        return {8'(kind), 8'(cs), 8'(i), 72'h0, 8'(kind ^ i), 8'(cs), 8'(i), 8'hE1};
    endfunction

    // R3 encoding: base[31:0], reg[36:32], count[41:37], type[44:42], valid[45]
    function automatic logic [WW-1:0] enc(input logic [2:0] ty, input logic [IW-1:0] cnt,
                                          input logic [IW-1:0] rg, input logic [AW-1:0] b);
        logic [WW-1:0] w;
        w = '0;
        w[31:0]  = b;
        w[36:32] = rg;
        w[41:37] = cnt;
        w[44:42] = ty;
        w[45]    = 1'b1;
        return w;
    endfunction

    // Vector: [17] op_ret [16] world [15] is_cap [14] valid [13:11] type
    //         [10:6] count [5:1] reg [0] expected exception
    localparam logic [17:0] VEC [12] = '{
        {1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 5'd3,  5'd0, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 5'd0,  5'd9, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 5'd31, 5'd4, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 5'd4,  5'd0, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 5'd0,  5'd0, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 5'd5,  5'd7, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 5'd31, 5'd2, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 5'd3,  5'd0, 1'b1},
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 5'd3,  5'd0, 1'b1},
        {1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 5'd3,  5'd0, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 5'd3,  5'd0, 1'b1},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 5'd3,  5'd1, 1'b1}
    };

    logic [WW-1:0] exp_rf [NR];
    logic [WW-1:0] exp_mem [NR];
    logic          exp_lw [128];
    logic [IW-1:0] exp_ls [128];
    logic [WW-1:0] exp_pc, exp_ehr;
    int            exp_n;

    task automatic push_op(input logic w, input int s);
        exp_lw[exp_n] = w;
        exp_ls[exp_n] = IW'(s);
        exp_n++;
    endtask

    task automatic run_case(input int cs, input logic [17:0] v, input bit stall, input bit restart);
        logic          r, xe;
        logic [2:0]    ty;
        logic [IW-1:0] cnt, rg;
        logic [AW-1:0] iv;
        bit            got_done, got_exc;
        int            k, bad;
        string         tag_ld, tag_st;
        r   = v[17];
        ty  = v[13:11];
        cnt = v[10:6];
        rg  = v[5:1];
        xe  = v[0];
        iv  = 32'hBE00_0000 | 32'(cs);
        tag_ld = !r ? "R4 R6" : (rg == 0 ? "R7" : "R8");
        tag_st = !r ? "R5" : "R9";
        for (int i = 0; i < NR; i++) begin
            mem_seed[i] = mk(1, cs, i);
            rf_seed[i]  = (i == 0) ? '0 : mk(2, cs, i);
        end
        pc_seed = mk(3, cs, 0);
        for (int i = 0; i < NR; i++) begin
            exp_rf[i]  = rf_seed[i];
            exp_mem[i] = mem_seed[i];
        end
        exp_pc  = pc_seed;
        exp_ehr = '0;
        exp_n   = 0;
        if (!xe) begin
            exp_pc = mem_seed[0];
            push_op(0, 0);
            if (!r) begin
                for (int i = 1; i <= int'(cnt); i++) begin
                    exp_rf[i] = mem_seed[i];
                    push_op(0, i);
                end
                exp_mem[0] = pc_seed;
                exp_mem[1] = rf_seed[2];
                push_op(1, 0);
                push_op(1, 1);
                exp_rf[1] = enc(3'd5, cnt, rg, cur_base_of(cs));
            end else begin
                if (rg == 0) begin
                    for (int i = 1; i < NR; i++) begin
                        exp_rf[i] = mem_seed[i];
                        push_op(0, i);
                    end
                end else begin
                    exp_rf[2] = mem_seed[1];
                    push_op(0, 1);
                end
                exp_mem[0] = {pc_seed[WW-1:AW], iv};
                push_op(1, 0);
                for (int i = 1; i <= int'(cnt); i++) begin
                    exp_mem[i] = rf_seed[i];
                    push_op(1, i);
                end
                if (rg == 0) exp_ehr = enc(3'd4, cnt, rg, cur_base_of(cs));
                else         exp_rf[rg] = enc(3'd4, cnt, rg, cur_base_of(cs));
            end
        end

        @(negedge clk);
        cur_base = cur_base_of(cs);
        init_go  = 1;
        log_clr  = 1;
        stall_en = stall;
        @(negedge clk);
        init_go      = 0;
        log_clr      = 0;
        op_ret       = r;
        world_secure = v[16];
        opnd_is_cap  = v[15];
        opnd_valid   = v[14];
        opnd_type    = ty;
        opnd_count   = cnt;
        opnd_reg     = rg;
        opnd_base    = cur_base;
        int_opnd     = iv;
        start        = 1;
        @(negedge clk);
        start = 0;
        k = 0;
        while (!(done || exc) && k < 3000) begin
            @(negedge clk);
            k++;
            if (restart && k == 4) begin
                start = 1; op_ret = ~r; opnd_type = 3'd5; opnd_reg = 5'd0;
            end else begin
                start = 0;
            end
        end
        start    = 0;
        got_done = done;
        got_exc  = exc;
        chk(k < 3000, "R11", "operation finished", WW'(k), WW'(3000));
        chk(got_exc == xe, "R2", "exception flag", WW'(got_exc), WW'(xe));
        chk(got_done == !xe, "R11", "done flag", WW'(got_done), WW'(!xe));
        @(negedge clk);
        chk(!busy && !done && !exc, "R11", "idle after finish",
            WW'({busy, done, exc}), WW'(0));
        if (xe) chk(traffic == 0, "R2", "no traffic on fault", WW'(traffic), WW'(0));
        chk(!addr_bad, "R3", "slot addresses in region", WW'(addr_bad), WW'(0));
        chk(pc_q == exp_pc, tag_ld, "pc", pc_q, exp_pc);
        bad = -1;
        for (int i = NR - 1; i >= 0; i--) if (rf[i] !== exp_rf[i]) bad = i;
        if (bad >= 0) chk(0, tag_ld, $sformatf("x%0d", bad), rf[bad], exp_rf[bad]);
        else          chk(1, tag_ld, "regs", '0, '0);
        chk(rf[0] == '0, "R12", "x0", rf[0], '0);
        bad = -1;
        for (int i = NR - 1; i >= 0; i--) if (mem[i] !== exp_mem[i]) bad = i;
        if (bad >= 0) chk(0, tag_st, $sformatf("slot %0d", bad), mem[bad], exp_mem[bad]);
        else          chk(1, tag_st, "slots", '0, '0);
        chk(ehr_q == exp_ehr, "R7", "exception-handler word", ehr_q, exp_ehr);
        chk(n_ops == exp_n, "R10", "access count", WW'(n_ops), WW'(exp_n));
        bad = -1;
        for (int i = exp_n - 1; i >= 0; i--)
            if (i < n_ops && (log_w[i] !== exp_lw[i] || log_s[i] !== exp_ls[i])) bad = i;
        if (bad >= 0) chk(0, "R10", $sformatf("access order at %0d", bad),
                          WW'({log_w[bad], log_s[bad]}), WW'({exp_lw[bad], exp_ls[bad]}));
        else          chk(1, "R10", "access order", '0, '0);
        stall_en = 0;
    endtask

    function automatic logic [AW-1:0] cur_base_of(input int cs);
        return 32'h1000 + 32'(cs) * 32'h400;
    endfunction

    bit wd_hit = 0;
    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
        fails++;
        checks++;
        $display("FAIL R11 watchdog: actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !exc && !mem_req_valid && !rf_we && !pc_we && !ehr_we,
            "R1", "outputs in reset", WW'({busy, done, exc, mem_req_valid, rf_we, pc_we, ehr_we}), '0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !exc && !mem_req_valid && !rf_we && !pc_we && !ehr_we,
            "R1", "outputs after reset", WW'({busy, done, exc, mem_req_valid, rf_we, pc_we, ehr_we}), '0);
        for (int n = 0; n < 12; n++) run_case(n, VEC[n], 0, 0);
        // Directed: stalled handshake (R10) on a return and on a call
        run_case(20, VEC[3], 1, 0);
        run_case(21, VEC[6], 1, 0);
        run_case(23, VEC[2], 1, 0);
        // Directed: start during busy is ignored (R11)
        run_case(22, VEC[0], 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule